// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block remembers why the chip was last reset. It sits in the always-on domain and runs from the slow always-on clock. Each reset source reaches it as a level that is synchronous to that clock: power-on, full system reset, software-triggered digital reset, always-on watchdog, sleep, and the processor's system-reset request. While recording is enabled, every slow-clock cycle with a source active ORs that cause's code into a six-bit flag field. Flags gather over successive resets and stay set until software clears them.

Software reaches the recorder through one 32-bit register on the fast system clock. A write is captured on the fast side and carried to the slow domain by a toggle handshake. There it can clear flags, write-one-to-clear, and it can switch recording on. Switching on needs two key bits in the same write. The flag field and the enable state come back through a two-flop synchronizer. A stability filter then takes the value only when two successive samples agree. A ready bit shows that the enable has been accepted on the slow side.

The only reset is the always-on power-on reset. None of the recorded resets touches the stored state.

Top module: `rst_cause_rec`

## Requirements
- R1: Flags accumulate. A set flag stays 1 until it is cleared by a write, and a later cause ORs its bits into the existing value.
- R2: Each cause sets a fixed set of readable bits. Power-on sets bits 5 and 4. Full system reset sets bits 5 and 3. Watchdog reset sets bits 5 and 2. Sleep sets bit 5 only. System-reset request sets bit 0 only.
- R3: A software-triggered digital reset records the same bits as a full system reset (bits 5 and 3).
- R4: Writing 1 to any of bits 0..5 clears that flag. Writing 0 leaves the flag unchanged.
- R5: Recording is enabled only by one write that has both bit 24 and bit 31 at 1. A write with only one of these bits set leaves recording off.
- R6: Bit 16 reads 0 after power-on. It reads 1 once the enable has crossed to the slow domain, and stays 1 until the next power-on reset.
- R7: While recording is off, reset causes set no flag.
- R8: If a cause and a clear hit the same flag in the same slow-clock cycle, the flag ends at 1.
- R9: Bits 1, 6..15, 17..23 and 24..31 always read 0, including after writes that set them.
- R10: A write that arrives while an earlier write is still crossing to the slow domain is ignored.
- R11: After the always-on power-on reset, all 32 read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock for the register access |
| clk_aon | input | 1 | Slow always-on clock |
| aon_por_n | input | 1 | Active-low always-on power-on reset, asynchronous |
| cause_por | input | 1 | Power-on cause, level synchronous to clk_aon |
| cause_full | input | 1 | Full system reset cause |
| cause_swrst | input | 1 | Software digital reset cause |
| cause_wdt | input | 1 | Always-on watchdog reset cause |
| cause_sleep | input | 1 | Sleep reset cause |
| cause_sysreq | input | 1 | Processor system-reset request cause |
| bus_wr | input | 1 | Register write strobe, one clk_sys cycle |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read value |

## Verification
The assertions assume that the cause inputs change only away from clk_aon edges, and that the fast-side write holding register stays stable while a transfer is in flight. They also assume that aon_por_n is not released in the middle of a transfer. To stay within these limits, the stimulus drives causes on falling clk_aon edges and issues writes on falling clk_sys edges. It asserts the power-on reset only at the start. It keeps writes a full handshake apart, except for one back-to-back pair that deliberately exercises R10. The model applies writes at issue time, so comparisons on every clock accept any model value from the last 64 fast cycles. Exact comparisons are made only after the design has settled.

// File: rtl/rst_cause_rec.sv
module rst_cause_rec (
  input  logic        clk_sys,
  input  logic        clk_aon,
  input  logic        aon_por_n,
  input  logic        cause_por,
  input  logic        cause_full,
  input  logic        cause_swrst,
  input  logic        cause_wdt,
  input  logic        cause_sleep,
  input  logic        cause_sysreq,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  // fast side: write capture and request toggle
  logic       req_t, key_h, ack_s1, ack_s2, busy;
  logic [5:0] clr_h;
  // slow side: request sync, flags, enable
  logic       req_s1, req_s2, req_s3, apply, en_q;
  logic [5:0] flag_q, set_v, clr_eff;
  // fast side: status sync and stable filter
  logic [6:0] st_s1, st_s2, st_vis;

  assign busy = req_t ^ ack_s2;

  always_ff @(posedge clk_sys or negedge aon_por_n) begin
    if (!aon_por_n) begin
      req_t  <= 1'b0;
      key_h  <= 1'b0;
      clr_h  <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (bus_wr && !busy) begin
        clr_h <= bus_wdata[5:0];
        key_h <= bus_wdata[24] & bus_wdata[31];
        req_t <= ~req_t;
      end
    end
  end

  assign apply   = req_s2 ^ req_s3;
  assign clr_eff = apply ? clr_h : 6'd0;

  always_comb begin
    set_v    = '0;
    set_v[5] = cause_por | cause_full | cause_swrst | cause_wdt | cause_sleep;
    set_v[4] = cause_por;
    set_v[3] = cause_full | cause_swrst;
    set_v[2] = cause_wdt;
    set_v[0] = cause_sysreq;
    if (!en_q) set_v = '0;
  end

  always_ff @(posedge clk_aon or negedge aon_por_n) begin
    if (!aon_por_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= '0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      en_q   <= en_q | (apply & key_h);
      flag_q <= (flag_q & ~clr_eff) | set_v;
    end
  end

  always_ff @(posedge clk_sys or negedge aon_por_n) begin
    if (!aon_por_n) begin
      st_s1  <= '0;
      st_s2  <= '0;
      st_vis <= '0;
    end else begin
      st_s1 <= {en_q, flag_q};
      st_s2 <= st_s1;
      if (st_s1 == st_s2) st_vis <= st_s2;
    end
  end

  assign bus_rdata = {15'd0, st_vis[6], 10'd0, st_vis[5:0]};

  a_r1_sticky: assert property (@(posedge clk_aon) disable iff (!aon_por_n)
    (($past(flag_q) & ~$past(clr_eff) & ~flag_q) == 6'd0));

  a_r2_power_bit: assert property (@(posedge clk_aon) disable iff (!aon_por_n)
    ((flag_q[4:2] & ~$past(flag_q[4:2])) != 3'd0) |-> flag_q[5]);

  a_r5_two_keys: assert property (@(posedge clk_aon) disable iff (!aon_por_n)
    $rose(en_q) |-> $past(apply && key_h));

  a_r6_ready_holds: assert property (@(posedge clk_sys) disable iff (!aon_por_n)
    $past(bus_rdata[16]) |-> bus_rdata[16]);

  a_r7_off_no_set: assert property (@(posedge clk_aon) disable iff (!aon_por_n)
    !$past(en_q) |-> ((flag_q & ~$past(flag_q)) == 6'd0));

  a_r8_set_wins: assert property (@(posedge clk_aon) disable iff (!aon_por_n)
    $past(en_q) |-> ((flag_q & $past(set_v)) == $past(set_v)));

  a_r10_busy_drop: assert property (@(posedge clk_sys) disable iff (!aon_por_n)
    $past(bus_wr && busy) |-> ($stable(clr_h) && $stable(key_h) && $stable(req_t)));

endmodule

// File: tb/tb_rst_cause_rec.sv
module tb_rst_cause_rec;
  logic clk_sys = 0, clk_aon = 0, aon_por_n = 0;
  logic cause_por = 0, cause_full = 0, cause_swrst = 0, cause_wdt = 0, cause_sleep = 0, cause_sysreq = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;

  int checks = 0, fails = 0, clk_fails = 0;
  bit done = 0, track = 0;
  logic       m_en = 0;
  logic [5:0] m_flags = 0;
  logic [31:0] hist [64];

  rst_cause_rec dut (.*);

  always #4 clk_sys = ~clk_sys;
  initial begin #1; forever #32 clk_aon = ~clk_aon; end

  function automatic logic [31:0] expv();
    return {15'd0, m_en, 10'd0, m_flags};
  endfunction

  // reference model: slow-domain recording
  always @(posedge clk_aon) begin
    if (aon_por_n && m_en) begin
      if (cause_por)              m_flags = m_flags | 6'h30;
      if (cause_full||cause_swrst) m_flags = m_flags | 6'h28;
      if (cause_wdt)              m_flags = m_flags | 6'h24;
      if (cause_sleep)            m_flags = m_flags | 6'h20;
      if (cause_sysreq)           m_flags = m_flags | 6'h01;
    end
  end

  always @(posedge clk_sys) begin
    for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = expv();
  end

  // every-clock comparison against recent model history
  always @(negedge clk_sys) if (track) begin
    bit hit = (bus_rdata == expv());
    for (int i = 0; i < 64; i++) if (hist[i] == bus_rdata) hit = 1;
    checks++;
    if (!hit) begin
      fails++; clk_fails++;
      if (clk_fails < 10)
        $display("FAIL R1 clock compare: actual=%h expected=%h (or recent)", bus_rdata, expv());
    end
  end

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, bus_rdata, exp);
    end
  endtask

  task automatic settle();
    repeat (80) @(posedge clk_sys);
    @(negedge clk_sys);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk_sys);
    bus_wr = 1; bus_wdata = d;
    m_flags = m_flags & ~d[5:0];
    if (d[24] && d[31]) m_en = 1;
    @(negedge clk_sys);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk_aon);
    case (which)
      0: cause_por = 1; 1: cause_full = 1; 2: cause_swrst = 1;
      3: cause_wdt = 1; 4: cause_sleep = 1; default: cause_sysreq = 1;
    endcase
    @(negedge clk_aon);
    {cause_por, cause_full, cause_swrst, cause_wdt, cause_sleep, cause_sysreq} = '0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) hist[i] = 0;
    repeat (5) @(posedge clk_sys);
    aon_por_n = 1;
    track = 1;
    @(negedge clk_sys);
    check("R11 reset state", 32'h0);
    // R7: recording off
    pulse(0); pulse(5); settle();
    check("R7 causes ignored while off", 32'h0);
    // R5: single key writes
    wr(32'h0100_0000); settle();
    check("R5 bit24 alone", 32'h0);
    wr(32'h8000_0000); settle();
    check("R5 bit31 alone", 32'h0);
    // R5 R6: both keys
    wr(32'h8100_0000); settle();
    check("R6 ready after enable", 32'h0001_0000);
    // R2 encodings
    pulse(4); settle(); check("R2 sleep bit5 only", 32'h0001_0020);
    wr(32'h3F); settle(); check("R4 clear all", 32'h0001_0000);
    pulse(0); settle(); check("R2 power-on", 32'h0001_0030);
    wr(32'h3F); settle();
    pulse(1); settle(); check("R2 full system", 32'h0001_0028);
    wr(32'h3F); settle();
    pulse(2); settle(); check("R3 software reset as full", 32'h0001_0028);
    wr(32'h3F); settle();
    pulse(3); settle(); check("R2 watchdog", 32'h0001_0024);
    wr(32'h3F); settle();
    pulse(5); settle(); check("R2 system request bit0", 32'h0001_0001);
    // R1 accumulate
    pulse(3); settle(); check("R1 accumulate", 32'h0001_0025);
    // R4 partial clear, zeros leave bits
    wr(32'h01); settle(); check("R4 partial clear", 32'h0001_0024);
    // R9 reserved bits ignored and zero
    wr(32'h7EFF_FFC2); settle(); check("R9 reserved read zero", 32'h0001_0024);
    // R6 ready stays after further key write
    wr(32'h8100_0000); settle(); check("R6 ready stays", 32'h0001_0024);
    // R10 back-to-back write dropped
    pulse(5); settle();
    @(negedge clk_sys);
    bus_wr = 1; bus_wdata = 32'h01; m_flags = m_flags & ~6'h01;
    @(negedge clk_sys);
    bus_wdata = 32'h04;
    @(negedge clk_sys);
    bus_wr = 0; bus_wdata = 0;
    settle(); check("R10 write in transit dropped", 32'h0001_0024);
    // R8 set wins over simultaneous clear
    wr(32'h3F); settle();
    @(negedge clk_aon); cause_wdt = 1;
    repeat (2) @(negedge clk_aon);
    wr(32'h3F);
    repeat (6) @(negedge clk_aon);
    cause_wdt = 0;
    settle(); check("R8 set wins", 32'h0001_0024);
    done = 1;
    track = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule